// File: doc/BRIEF.md
# Wake Event Source Latch

This block records which wake event brought the system back from a sleep state to the working state. It watches a vector of general-purpose event status lines and a vector of fixed power-management status lines. While the system is asleep and the latch is armed, the first status line that newly asserts is captured as the single wake source. The general-purpose source register then holds that line's index. The fixed source register holds the bit position within the fixed status word. The register that did not capture keeps the all-ones code, meaning "unknown".

When the sleep indication rises, both source registers return to all-ones and the latch arms again. The first qualifying event locks both registers until the next sleep entry. Events that arrive later, including any during the working state, cannot replace the recorded source. If the system wakes without a qualifying event, both registers read all-ones for the whole working residency.

Software reads either 32-bit source register through a simple read port. A read has no side effects, so the same value comes back on every read.

Top module: `wake_src_latch`

## Requirements
- R1: After reset both source registers read 0xFFFFFFFF and the latch is not armed. Status activity after reset and before the first sleep entry changes neither register.
- R2: On the first cycle that `sleep_active` is sampled high after being low, both registers are set to 0xFFFFFFFF and the latch arms. Status edges sampled in that same entry cycle are not captured.
- R3: While armed and `sleep_active` is high, a rising general-purpose line i writes the value i, zero-extended, into the general-purpose register. The fixed register stays 0xFFFFFFFF.
- R4: While armed and `sleep_active` is high, a rising fixed line j with no general-purpose edge in that cycle writes j, zero-extended, into the fixed register. The general-purpose register stays 0xFFFFFFFF.
- R5: When several lines of one vector rise in the same cycle, the lowest index is recorded.
- R6: When general-purpose and fixed edges arrive in the same cycle, the general-purpose index is recorded and the fixed register stays 0xFFFFFFFF.
- R7: After a capture, later edges on either vector change neither register until the next sleep entry.
- R8: Only a 0-to-1 transition of a status line, sampled on consecutive clocks, is an event. A line that is already high at sleep entry causes no capture.
- R9: Waking (`sleep_active` low) disarms the latch. If nothing was captured, both registers stay 0xFFFFFFFF through the working residency, and status edges in that residency are ignored.
- R10: A read with `rd_en` high returns the general-purpose register when `rd_addr` = 0 and the fixed register when `rd_addr` = 1. `rd_data` and `rd_valid` appear one cycle after the request. Reads have no side effects, so repeated reads return identical data.
- R11: Every new sleep entry determines the source afresh, replacing the value recorded in the previous sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_active | input | 1 | High while the system is in a sleep state |
| gpe_sts | input | GPE_W | General-purpose event status lines |
| fix_sts | input | FIX_W | Fixed power-management status lines |
| rd_en | input | 1 | Read request |
| rd_addr | input | 1 | Register select: 0 general-purpose source, 1 fixed source |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after a read request |

## Verification
An edge on a status line is captured at the same clock edge that samples it, provided the previous sample of that line was low. A sleep entry clears the registers at the edge that first samples `sleep_active` high. Read data appears one clock after the sampled request. The bench drives every input on the falling edge and issues reads only after a stimulus has had at least one rising edge to land. Each read pushes its expected value into a queue, and a monitor compares results on the falling edge whenever `rd_valid` is high, so each comparison happens in the cycle the data is due.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
    localparam int REG_W = 32;
    localparam logic [REG_W-1:0] SRC_UNKNOWN = '1;

    typedef enum logic {
        SEL_GPE = 1'b0,
        SEL_FIX = 1'b1
    } rd_sel_e;

    typedef struct packed {
        logic             hit;
        logic [REG_W-1:0] idx;
    } src_hit_t;

    function automatic logic [REG_W-1:0] pick_src(input rd_sel_e sel,
                                                  input logic [REG_W-1:0] g,
                                                  input logic [REG_W-1:0] f);
        return (sel == SEL_GPE) ? g : f;
    endfunction
endpackage

// File: rtl/wsl_edge_det.sv
module wsl_edge_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lines,
    output logic [W-1:0] rose
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lines;
    end

    assign rose = lines & ~prev_q;
endmodule

// File: rtl/wsl_prio_enc.sv
module wsl_prio_enc
    import wsl_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] req,
    output src_hit_t     win
);
    always_comb begin
        win.hit = 1'b0;
        win.idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                win.hit = 1'b1;
                win.idx = REG_W'(i);
            end
        end
    end
endmodule

// File: rtl/wsl_src_regs.sv
module wsl_src_regs
    import wsl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_active,
    input  src_hit_t         gpe_win,
    input  src_hit_t         fix_win,
    output logic [REG_W-1:0] gpe_src,
    output logic [REG_W-1:0] fix_src,
    output logic             armed
);
    logic sleep_q;
    logic entry;

    assign entry = sleep_active & ~sleep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_q <= 1'b0;
            armed   <= 1'b0;
            gpe_src <= SRC_UNKNOWN;
            fix_src <= SRC_UNKNOWN;
        end else begin
            sleep_q <= sleep_active;
            if (entry) begin
                armed   <= 1'b1;
                gpe_src <= SRC_UNKNOWN;
                fix_src <= SRC_UNKNOWN;
            end else if (!sleep_active) begin
                armed <= 1'b0;
            end else if (armed) begin
                if (gpe_win.hit) begin
                    gpe_src <= gpe_win.idx;
                    armed   <= 1'b0;
                end else if (fix_win.hit) begin
                    fix_src <= fix_win.idx;
                    armed   <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/wsl_rd_port.sv
module wsl_rd_port
    import wsl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             rd_addr,
    input  logic [REG_W-1:0] gpe_src,
    input  logic [REG_W-1:0] fix_src,
    output logic [REG_W-1:0] rd_data,
    output logic             rd_valid
);
    rd_sel_e sel;
    assign sel = rd_sel_e'(rd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= pick_src(sel, gpe_src, fix_src);
        end
    end
endmodule

// File: rtl/wake_src_latch.sv
module wake_src_latch
    import wsl_pkg::*;
#(
    parameter int GPE_W = 16,
    parameter int FIX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_active,
    input  logic [GPE_W-1:0] gpe_sts,
    input  logic [FIX_W-1:0] fix_sts,
    input  logic             rd_en,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             rd_valid
);
    logic [GPE_W-1:0] gpe_rose;
    logic [FIX_W-1:0] fix_rose;
    src_hit_t         gpe_win;
    src_hit_t         fix_win;
    logic [REG_W-1:0] gpe_src_q;
    logic [REG_W-1:0] fix_src_q;
    logic             armed_q;

    wsl_edge_det #(.W(GPE_W)) u_gpe_edge (
        .clk(clk), .rst(rst), .lines(gpe_sts), .rose(gpe_rose)
    );
    wsl_edge_det #(.W(FIX_W)) u_fix_edge (
        .clk(clk), .rst(rst), .lines(fix_sts), .rose(fix_rose)
    );

    wsl_prio_enc #(.W(GPE_W)) u_gpe_enc (.req(gpe_rose), .win(gpe_win));
    wsl_prio_enc #(.W(FIX_W)) u_fix_enc (.req(fix_rose), .win(fix_win));

    wsl_src_regs u_regs (
        .clk(clk), .rst(rst), .sleep_active(sleep_active),
        .gpe_win(gpe_win), .fix_win(fix_win),
        .gpe_src(gpe_src_q), .fix_src(fix_src_q), .armed(armed_q)
    );

    wsl_rd_port u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .gpe_src(gpe_src_q), .fix_src(fix_src_q),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/wake_src_latch_chk.sv
module wake_src_latch_chk
    import wsl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sleep_active,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [REG_W-1:0] gpe_src,
    input logic [REG_W-1:0] fix_src,
    input logic             armed
);
    // R1
    rst_unknown_chk: assert property (@(posedge clk)
        rst |=> (gpe_src == SRC_UNKNOWN && fix_src == SRC_UNKNOWN && !armed));

    // R2
    entry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_active) |=> (gpe_src == SRC_UNKNOWN && fix_src == SRC_UNKNOWN));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !$rose(sleep_active)) |=> ($stable(gpe_src) && $stable(fix_src)));

    // R9
    awake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sleep_active |=> ($stable(gpe_src) && $stable(fix_src)));

    // R6
    single_src_chk: assert property (@(posedge clk) disable iff (rst)
        (gpe_src == SRC_UNKNOWN) || (fix_src == SRC_UNKNOWN));

    // R10
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
endmodule

bind wake_src_latch wake_src_latch_chk u_chk (
    .clk(clk), .rst(rst), .sleep_active(sleep_active),
    .rd_en(rd_en), .rd_valid(rd_valid),
    .gpe_src(gpe_src_q), .fix_src(fix_src_q), .armed(armed_q)
);

// File: tb/wake_src_latch_tb.sv
`timescale 1ns/1ps
module wake_src_latch_tb;
    localparam logic [31:0] UNK = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_active = 1'b0;
    logic [15:0] gpe_sts = '0;
    logic [15:0] fix_sts = '0;
    logic        rd_en = 1'b0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    wake_src_latch u_dut (
        .clk(clk), .rst(rst), .sleep_active(sleep_active),
        .gpe_sts(gpe_sts), .fix_sts(fix_sts),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // monitor: compare each read result in the cycle it is due
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL unexpected read data: actual %h expected none", rd_data);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rd_data !== e.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", e.tag, rd_data, e.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic a, input logic [31:0] e, input string tag);
        @(negedge clk);
        sb.push_back('{e, tag});
        rd_addr = a;
        rd_en   = 1'b1;
        @(negedge clk);
        rd_en   = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] gm, input logic [15:0] fm);
        @(negedge clk);
        gpe_sts = gpe_sts | gm;
        fix_sts = fix_sts | fm;
        @(negedge clk);
        gpe_sts = gpe_sts & ~gm;
        fix_sts = fix_sts & ~fm;
        step(1);
    endtask

    task automatic go_sleep();
        @(negedge clk);
        sleep_active = 1'b1;
        step(2);
    endtask

    task automatic wake();
        @(negedge clk);
        sleep_active = 1'b0;
        step(2);
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        step(2);
        rd(1'b0, UNK, "R1 gpe after reset");
        rd(1'b1, UNK, "R1 fix after reset");
        pulse(16'h0010, 16'h0001);
        rd(1'b0, UNK, "R1 gpe edge before any sleep");

        go_sleep();
        pulse(16'h0020, 16'h0000);
        rd(1'b0, 32'd5, "R3 gpe index 5");
        rd(1'b1, UNK,   "R3 fix untouched");
        pulse(16'h0004, 16'h0000);
        rd(1'b0, 32'd5, "R7 later gpe ignored");
        pulse(16'h0000, 16'h0008);
        rd(1'b1, UNK,   "R7 later fix ignored");
        wake();
        rd(1'b0, 32'd5, "R10 first read");
        rd(1'b0, 32'd5, "R10 repeated read");
        pulse(16'h0001, 16'h0000);
        rd(1'b0, 32'd5, "R9 working-state event ignored");

        go_sleep();
        rd(1'b0, UNK, "R2 gpe cleared on entry");
        rd(1'b1, UNK, "R2 fix cleared on entry");
        pulse(16'h0000, 16'h0110);
        rd(1'b1, 32'd4, "R4 R5 fix lowest index 4");
        rd(1'b0, UNK,   "R4 gpe untouched");
        wake();

        go_sleep();
        pulse(16'h1200, 16'h0002);
        rd(1'b0, 32'd9, "R5 R6 gpe 9 wins");
        rd(1'b1, UNK,   "R6 fix stays unknown");
        wake();

        // line 7 held across entry, line 3 rises in the entry cycle
        @(negedge clk);
        gpe_sts = 16'h0080;
        step(2);
        @(negedge clk);
        sleep_active = 1'b1;
        gpe_sts = 16'h0088;
        step(3);
        rd(1'b0, UNK, "R8 held and entry-cycle lines not captured");
        wake();
        gpe_sts = '0;
        step(1);
        pulse(16'h0002, 16'h0000);
        rd(1'b0, UNK, "R9 gpe unknown wake");
        rd(1'b1, UNK, "R9 fix unknown wake");

        go_sleep();
        pulse(16'h8000, 16'h0000);
        rd(1'b0, 32'd15, "R11 fresh capture index 15");
        wake();

        step(4);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R10 missing reads: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule